// File: doc/BRIEF.md
# PWM Compare Output Waveform Generator

This block produces the waveform for one compare-output pin from an 8-bit timer that runs in one of two pulse-width modes. In single-slope mode the counter climbs from BOTTOM (0x00) to TOP (0xFF) and wraps. In dual-slope mode it climbs to TOP, turns, and falls back to BOTTOM, turning again at each end. A registered output level is set or cleared on compare matches and at the slope end points, as chosen by a 2-bit output-action field. The count advances, and the output changes, only on cycles where the clock-enable tick is high.

The compare value is double-buffered. The active compare register takes the new value on the tick that finds the counter at TOP, so the duty cycle never changes partway through a period. When the output-action field has its upper bit clear, the waveform is detached from the pin. The override flag then tells the pad logic to use the pin as an ordinary port, and the waveform register keeps its value. A compare value equal to TOP is a special case. Its match is ignored, and the pin changes at the slope end point instead.

Top module: `pwm_compare_out`

## Requirements
- R1: After reset the count is 0, the direction flag is 0 (counting up), the waveform output is 0 and the active compare value is 0.
- R2: On a cycle with `tick` low the count, the direction flag and the waveform output all hold their values.
- R3: With `mode_sel` = 0 (single-slope) each tick adds one to the count, 0xFF is followed by 0x00, and the direction flag is forced to 0.
- R4: With `mode_sel` = 1 (dual-slope) a tick at 0xFF while counting up gives 0xFE with the flag set to 1 (down). A tick at 0x00 while counting down gives 0x01 with the flag set to 0. Any other tick moves the count one step in the flagged direction.
- R5: `com_mode` values 00 and 01 drive `pin_override` low, and the waveform register keeps its value. Values 10 and 11 drive `pin_override` high in the same cycle.
- R6: In single-slope mode with `com_mode` = 10, a tick where the count equals the active compare value (other than 0xFF) clears the output. Otherwise, a tick at count 0x00 sets it. The match wins when both apply.
- R7: In single-slope mode with `com_mode` = 11, the match sets the output and the 0x00 point clears it, with the same priority as R6.
- R8: In dual-slope mode a match tick (active compare value other than 0xFF) drives the output to `com_mode[0]` while the flag is 0 (up), and to the inverse of `com_mode[0]` while the flag is 1 (down).
- R9: When the active compare value is 0xFF, no match is taken. Single-slope mode drives the output to the inverse of `com_mode[0]` on the tick at 0x00. Dual-slope mode does the same on the tick at 0xFF.
- R10: `cmp_value` is copied into the active compare register only on a tick whose count is 0xFF. That tick's match still uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock-enable tick for counter and output |
| mode_sel | input | 1 | 0 single-slope, 1 dual-slope |
| com_mode | input | 2 | Output action field |
| cmp_value | input | 8 | Compare value, buffered until TOP |
| wave_out | output | 1 | Waveform register |
| pin_override | output | 1 | High when the waveform owns the pin |
| count_out | output | 8 | Current count |
| count_down | output | 1 | Direction flag, 1 while counting down |

## Verification
The count, the direction flag and the waveform are registered. Each one therefore shows the effect of a tick one clock edge after that tick is applied, and it is judged against the count, flag and active compare value that were present before the edge. `pin_override` follows `com_mode` in the same cycle. The driver sets the inputs on a falling edge and computes the expected registered state for the next rising edge, then queues it. The monitor reads the outputs 1 ns after that rising edge, so every comparison lands in the cycle where the result is due. New compare values are applied partway through a period, so the queued expectations show the old value staying active until the tick at TOP.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic {
    PWM_SINGLE = 1'b0,
    PWM_DUAL   = 1'b1
  } pwm_mode_e;

  // upper bit of the action field attaches the waveform to the pin
  function automatic logic drives_pin(input logic [1:0] act);
    return act[1];
  endfunction

  // level applied on a compare match for the given slope direction
  function automatic logic match_level(input logic [1:0] act, input logic going_down);
    return going_down ? ~act[0] : act[0];
  endfunction

  // level applied at the slope end point (BOTTOM or TOP special case)
  function automatic logic end_level(input logic [1:0] act);
    return ~act[0];
  endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  pwm_mode_e    mode,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         at_top,
  output logic         at_bottom
);

  localparam logic [W-1:0] TOP    = {W{1'b1}};
  localparam logic [W-1:0] BOTTOM = '0;
  localparam logic [W-1:0] ONE    = {{(W-1){1'b0}}, 1'b1};

  typedef struct packed {
    logic [W-1:0] value;
    logic         dn;
  } step_t;

  function automatic step_t next_step(input pwm_mode_e m, input logic [W-1:0] c,
                                      input logic d);
    step_t s;
    if (m == PWM_SINGLE) begin
      s.value = c + ONE;
      s.dn    = 1'b0;
    end else if (!d) begin
      s.dn    = (c == TOP);
      s.value = (c == TOP) ? c - ONE : c + ONE;
    end else begin
      s.dn    = (c != BOTTOM);
      s.value = (c == BOTTOM) ? c + ONE : c - ONE;
    end
    return s;
  endfunction

  step_t nxt;
  assign nxt       = next_step(mode, cnt, down);
  assign at_top    = (cnt == TOP);
  assign at_bottom = (cnt == BOTTOM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (tick) begin
      cnt  <= nxt.value;
      down <= nxt.dn;
    end
  end

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt) && $stable(down)));

  assert_single_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == PWM_SINGLE && at_top) |=> (at_bottom && !down));

  assert_dual_turn_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == PWM_DUAL && at_top && !down) |=> (down && cnt == TOP - ONE));

  assert_dual_turn_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == PWM_DUAL && at_bottom && down) |=> (!down && cnt == ONE));

endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] cmp_in,
  output logic [W-1:0] cmp_act,
  output logic         cmp_is_top
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)    cmp_act <= '0;
    else if (load) cmp_act <= cmp_in;
  end

  assign cmp_is_top = (cmp_act == TOP);

  assert_buffer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmp_act));

  assert_buffer_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cmp_act == $past(cmp_in)));

endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  pwm_mode_e    mode,
  input  logic [1:0]   act,
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic [W-1:0] cmp_act,
  input  logic         cmp_is_top,
  output logic         wave,
  output logic         cmp_hit,
  output logic         end_event
);

  logic attached;
  logic wave_nxt;

  assign attached = drives_pin(act);
  // a compare value at TOP never produces a match
  assign cmp_hit  = (cnt == cmp_act) && !cmp_is_top;
  // end-point event: BOTTOM in single-slope, TOP (special case only) in dual-slope
  assign end_event = (mode == PWM_SINGLE) ? at_bottom : (cmp_is_top && at_top && !down);

  always_comb begin
    wave_nxt = wave;
    if (cmp_hit) begin
      wave_nxt = (mode == PWM_SINGLE) ? act[0] : match_level(act, down);
    end else if (end_event) begin
      wave_nxt = end_level(act);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 wave <= 1'b0;
    else if (tick && attached)  wave <= wave_nxt;
  end

  assert_detached_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !act[1] |=> $stable(wave));

  assert_wave_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave));

  assert_top_match_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act[1] && mode == PWM_SINGLE && cmp_is_top && !at_bottom) |=> $stable(wave));

  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act == 2'b10 && mode == PWM_SINGLE && cnt == cmp_act && !cmp_is_top) |=> !wave);

  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act == 2'b11 && mode == PWM_SINGLE && cnt == cmp_act && !cmp_is_top) |=> wave);

  assert_dual_down_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act[1] && mode == PWM_DUAL && down && cnt == cmp_act && !cmp_is_top)
      |=> (wave == ~$past(act[0])));

endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         mode_sel,
  input  logic [1:0]   com_mode,
  input  logic [W-1:0] cmp_value,
  output logic         wave_out,
  output logic         pin_override,
  output logic [W-1:0] count_out,
  output logic         count_down
);

  pwm_mode_e    mode;
  logic [W-1:0] cnt;
  logic         down;
  logic         at_top;
  logic         at_bottom;
  logic         load_cmp;
  logic [W-1:0] cmp_act;
  logic         cmp_is_top;
  logic         cmp_hit;
  logic         end_event;

  assign mode     = pwm_mode_e'(mode_sel);
  assign load_cmp = tick && at_top;

  pwm_counter #(.W(W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (mode),
    .cnt       (cnt),
    .down      (down),
    .at_top    (at_top),
    .at_bottom (at_bottom)
  );

  pwm_cmp_buf #(.W(W)) u_cmp_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_cmp),
    .cmp_in     (cmp_value),
    .cmp_act    (cmp_act),
    .cmp_is_top (cmp_is_top)
  );

  pwm_wave #(.W(W)) u_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode       (mode),
    .act        (com_mode),
    .cnt        (cnt),
    .down       (down),
    .at_top     (at_top),
    .at_bottom  (at_bottom),
    .cmp_act    (cmp_act),
    .cmp_is_top (cmp_is_top),
    .wave       (wave_out),
    .cmp_hit    (cmp_hit),
    .end_event  (end_event)
  );

  assign pin_override = drives_pin(com_mode);
  assign count_out    = cnt;
  assign count_down   = down;

  assert_override_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_override == com_mode[1]);

  assert_no_hit_at_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_is_top |-> !cmp_hit);

  assert_single_flag_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == PWM_SINGLE) |=> !count_down);

endmodule

// File: tb/pwm_compare_out_bench.sv
module pwm_compare_out_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       mode_sel = 1'b0;
  logic [1:0] com_mode = 2'b00;
  logic [7:0] cmp_value = 8'd0;
  logic       wave_out;
  logic       pin_override;
  logic [7:0] count_out;
  logic       count_down;

  always #2 clk = ~clk;

  pwm_compare_out u_pwm_compare_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .mode_sel     (mode_sel),
    .com_mode     (com_mode),
    .cmp_value    (cmp_value),
    .wave_out     (wave_out),
    .pin_override (pin_override),
    .count_out    (count_out),
    .count_down   (count_down)
  );

  typedef struct {
    int    cnt;
    int    dn;
    int    wv;
    int    ovr;
    string rc;
    string rw;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  // reference state
  int m_cnt = 0, m_dn = 0, m_wv = 0, m_ocr = 0;

  task automatic check(input string req, input int act, input int expv, input string what);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic run(input int n, input bit md, input logic [1:0] cm, input int cv,
                     input int div, input string tw);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      bit t;
      bit hit;
      @(negedge clk);
      t = ((i % div) == 0);
      tick = t; mode_sel = md; com_mode = cm; cmp_value = cv[7:0];
      if (t) begin
        hit = (m_ocr == m_cnt) && (m_ocr != 255);
        if (cm[1]) begin
          if (hit)
            m_wv = (md == 0) ? int'(cm[0]) : ((m_dn != 0) ? int'(!cm[0]) : int'(cm[0]));
          else if (md == 0 && m_cnt == 0)
            m_wv = int'(!cm[0]);
          else if (md == 1 && m_ocr == 255 && m_cnt == 255 && m_dn == 0)
            m_wv = int'(!cm[0]);
        end
        if (m_cnt == 255) m_ocr = cv;
        if (md == 0) begin
          m_cnt = (m_cnt == 255) ? 0 : m_cnt + 1;
          m_dn  = 0;
        end else if (m_dn == 0) begin
          if (m_cnt == 255) begin m_dn = 1; m_cnt = 254; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_dn = 0; m_cnt = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      e.cnt = m_cnt; e.dn = m_dn; e.wv = m_wv; e.ovr = int'(cm[1]);
      e.rc  = (div > 1) ? "R2" : (md ? "R4" : "R3");
      e.rw  = (div > 1) ? "R2" : tw;
      q.push_back(e);
    end
  endtask

  // monitor: compares one queued item per cycle, 1 ns after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.rc, int'(count_out), e.cnt, "count");
        check(e.rc, int'(count_down), e.dn, "direction");
        check(e.rw, int'(wave_out), e.wv, "wave");
        check("R5", int'(pin_override), e.ovr, "override");
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", int'(count_out), 0, "count");
    check("R1", int'(count_down), 0, "direction");
    check("R1", int'(wave_out), 0, "wave");
    @(negedge clk);
    rst_n = 1'b1;
    run(600, 0, 2'b10, 64, 1, "R6");
    run(300, 0, 2'b10, 64, 3, "R2");
    run(600, 0, 2'b11, 200, 1, "R7");
    run(300, 0, 2'b00, 20, 1, "R5");
    run(300, 0, 2'b01, 90, 1, "R5");
    run(600, 0, 2'b10, 255, 1, "R9");
    run(600, 0, 2'b11, 255, 1, "R9");
    run(120, 0, 2'b10, 30, 1, "R10");
    run(400, 0, 2'b10, 180, 1, "R10");
    run(600, 0, 2'b10, 0, 1, "R6");
    run(1200, 1, 2'b10, 100, 1, "R8");
    run(1200, 1, 2'b11, 30, 1, "R8");
    run(400, 1, 2'b10, 30, 3, "R2");
    run(1200, 1, 2'b10, 255, 1, "R9");
    run(1200, 1, 2'b11, 255, 1, "R9");
    run(300, 1, 2'b10, 200, 1, "R10");
    run(900, 1, 2'b10, 10, 1, "R10");
    run(300, 1, 2'b00, 50, 1, "R5");
    run(300, 0, 2'b11, 128, 1, "R3");
    @(negedge clk);
    tick = 1'b0;
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule